// File: doc/BRIEF.md
# Rotary Knob Delay Request Controller

This block turns a mechanical rotary knob into a coarse delay setting for an audio delay line. The knob contacts arrive already debounced as two phase signals. The block examines them only in a sampling slot that comes once every 64 audio frame strobes, about every 1.5 ms at common audio rates. In that slot, a falling edge on phase A moves an 8-bit delay request up or down by one. Phase B, read at the same moment, sets the direction.

In the same slot the block also latches a 4-bit program selector and turns it into an even program index. Downstream logic dispatches on that index. A separate stage, outside this block, glides the actual delay toward the requested value.

A single flag stands in for a full quadrature decoder. A low phase A steps the count once and sets the flag. A high phase A clears the flag again. All three external knob inputs pass through two-flop synchronizers before they are used.

Top module: `knob_delay_ctrl`

## Requirements
- R1: After synchronous reset, `delay_req` is 0, `prog_idx` is 2, and the edge flag is clear, so the first slot that sees phase A low takes a step.
- R2: A sampling slot is the clock edge at which the 64th `frame_tick` since reset, or since the previous slot, is high. Between slots, changes on `enc_a`, `enc_b` and `prog_sel` have no effect on either output.
- R3: In a slot where the synchronized phase A is 1, the edge flag clears and `delay_req` keeps its value.
- R4: In a slot where the synchronized phase A is 0 and the flag is clear, exactly one step is taken and the flag is set. Later slots with phase A still 0 take no step.
- R5: A step taken with the synchronized phase B at 0 is clockwise and adds 1 to `delay_req`.
- R6: A step taken with the synchronized phase B at 1 is counter-clockwise and subtracts 1 from `delay_req`.
- R7: `delay_req` wraps modulo 256: it goes from 255 up to 0 and from 0 down to 255.
- R8: In every slot `prog_idx` is loaded with 2*sel+2. Here sel is the synchronized `prog_sel` value. This equals the selector placed at bits 6..3 of a byte, shifted right by two, plus two.
- R9: The knob value used in a slot is the one present on the inputs at the clock edge two cycles before the slot edge. A change one cycle before the slot edge is not seen until a later slot.
- R10: Both outputs are registered and change only at the slot edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle strobe per audio frame, in the clock domain |
| enc_a | input | 1 | Debounced knob phase A (asynchronous) |
| enc_b | input | 1 | Debounced knob phase B (asynchronous) |
| prog_sel | input | 4 | Program selector switch (asynchronous) |
| delay_req | output | 8 | Coarse delay request, wrapping counter |
| prog_idx | output | 6 | Program index, 2*sel+2 |

## Verification
The properties assume that `frame_tick` is already synchronous to `clk`. They also assume that reset is held for at least two edges, so that the registered history they compare against holds reset values. The properties count frame strobes on their own to locate slots, and they judge each step from the synchronized phases, so they do not care how long the raw knob inputs stay stable. The stimulus uses both back-to-back strobes and spaced strobes. It also moves the knob inputs one and two cycles ahead of a slot edge and toggles them freely between slots. A behavioural model in the bench delays every input by two edges and counts strobes on its own, so these timing cases are judged without any assumption about how fast the knob moves.

// File: rtl/knob_pkg.sv
package knob_pkg;

    localparam int KNOB_DLY_W     = 8;
    localparam int KNOB_SEL_W     = 4;
    localparam int KNOB_SEL_LSB   = 3;
    localparam int KNOB_SEL_SHIFT = 2;
    localparam int KNOB_IDX_BASE  = 2;
    localparam int KNOB_IDX_W     = KNOB_SEL_W + 2;
    localparam int KNOB_FRAME_DIV = 64;

    typedef struct packed {
        logic                  ph_a;
        logic                  ph_b;
        logic [KNOB_SEL_W-1:0] sel;
    } knob_in_t;

    localparam int KNOB_IN_W = $bits(knob_in_t);

    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_UP    = 2'd1,
        STEP_DOWN  = 2'd2,
        STEP_CLEAR = 2'd3
    } step_act_t;

    function automatic logic [KNOB_IDX_W-1:0] sel_to_idx(input logic [KNOB_SEL_W-1:0] s);
        logic [KNOB_SEL_LSB+KNOB_SEL_W:0] port_byte;
        port_byte = '0;
        port_byte[KNOB_SEL_LSB +: KNOB_SEL_W] = s;
        return KNOB_IDX_W'((port_byte >> KNOB_SEL_SHIFT) + KNOB_IDX_BASE);
    endfunction

endpackage

// File: rtl/knob_sync.sv
module knob_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            d_sync <= '0;
        end else begin
            meta_q <= d_async;
            d_sync <= meta_q;
        end
    end
endmodule

// File: rtl/knob_slot_timer.sv
module knob_slot_timer #(
    parameter int FRAME_DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_tick,
    output logic slot
);
    localparam int CW = $clog2(FRAME_DIV + 1);
    logic [CW-1:0] left_q;

    assign slot = frame_tick && (left_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= CW'(FRAME_DIV);
        end else if (frame_tick) begin
            if (left_q == CW'(1)) left_q <= CW'(FRAME_DIV);
            else                  left_q <= left_q - CW'(1);
        end
    end
endmodule

// File: rtl/knob_step.sv
module knob_step
    import knob_pkg::*;
#(
    parameter int DLY_W = KNOB_DLY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot,
    input  logic             ph_a,
    input  logic             ph_b,
    output logic [DLY_W-1:0] delay_q,
    output logic             seen_q
);
    step_act_t act;

    always_comb begin
        act = STEP_HOLD;
        if (slot) begin
            if (ph_a)         act = STEP_CLEAR;
            else if (!seen_q) act = ph_b ? STEP_DOWN : STEP_UP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            delay_q <= '0;
            seen_q  <= 1'b0;
        end else begin
            unique case (act)
                STEP_CLEAR: seen_q <= 1'b0;
                STEP_UP: begin
                    seen_q  <= 1'b1;
                    delay_q <= delay_q + DLY_W'(1);
                end
                STEP_DOWN: begin
                    seen_q  <= 1'b1;
                    delay_q <= delay_q - DLY_W'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/knob_delay_ctrl.sv
module knob_delay_ctrl
    import knob_pkg::*;
#(
    parameter int FRAME_DIV = KNOB_FRAME_DIV,
    parameter int DLY_W     = KNOB_DLY_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_tick,
    input  logic                  enc_a,
    input  logic                  enc_b,
    input  logic [KNOB_SEL_W-1:0] prog_sel,
    output logic [DLY_W-1:0]      delay_req,
    output logic [KNOB_IDX_W-1:0] prog_idx
);
    knob_in_t raw_in;
    knob_in_t smp;
    logic     slot;
    logic     a_sy;
    logic     b_sy;
    logic     edge_seen;
    logic [KNOB_IDX_W-1:0] idx_q;

    assign raw_in = '{ph_a: enc_a, ph_b: enc_b, sel: prog_sel};

    knob_sync #(.W(KNOB_IN_W)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (raw_in),
        .d_sync  (smp)
    );

    assign a_sy = smp.ph_a;
    assign b_sy = smp.ph_b;

    knob_slot_timer #(.FRAME_DIV(FRAME_DIV)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .slot       (slot)
    );

    knob_step #(.DLY_W(DLY_W)) u_step (
        .clk     (clk),
        .rst     (rst),
        .slot    (slot),
        .ph_a    (a_sy),
        .ph_b    (b_sy),
        .delay_q (delay_req),
        .seen_q  (edge_seen)
    );

    always_ff @(posedge clk) begin
        if (rst)       idx_q <= sel_to_idx('0);
        else if (slot) idx_q <= sel_to_idx(smp.sel);
    end

    assign prog_idx = idx_q;
endmodule

// File: rtl/knob_delay_chk.sv
module knob_delay_chk #(
    parameter int FRAME_DIV = 64,
    parameter int DLY_W     = 8,
    parameter int IDX_W     = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_tick,
    input logic             a_sy,
    input logic             b_sy,
    input logic             edge_seen,
    input logic [DLY_W-1:0] delay_req,
    input logic [IDX_W-1:0] prog_idx
);
    localparam int CW = $clog2(FRAME_DIV) + 1;
    logic [CW-1:0] ticks_q;
    logic          slot_c;

    assign slot_c = frame_tick && (ticks_q == CW'(FRAME_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst)             ticks_q <= '0;
        else if (slot_c)     ticks_q <= '0;
        else if (frame_tick) ticks_q <= ticks_q + CW'(1);
    end

    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !slot_c |=> $stable(delay_req) && $stable(prog_idx) && $stable(edge_seen));

    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        slot_c && a_sy |=> !edge_seen && $stable(delay_req));

    p_once_r4: assert property (@(posedge clk) disable iff (rst)
        slot_c && !a_sy && edge_seen |=> edge_seen && $stable(delay_req));

    p_up_r5: assert property (@(posedge clk) disable iff (rst)
        slot_c && !a_sy && !edge_seen && !b_sy |=>
            edge_seen && (delay_req == DLY_W'($past(delay_req) + DLY_W'(1))));

    p_down_r6: assert property (@(posedge clk) disable iff (rst)
        slot_c && !a_sy && !edge_seen && b_sy |=>
            edge_seen && (delay_req == DLY_W'($past(delay_req) - DLY_W'(1))));

    p_index_form_r8: assert property (@(posedge clk) disable iff (rst)
        !prog_idx[0] && (prog_idx >= IDX_W'(2)));
endmodule

bind knob_delay_ctrl knob_delay_chk #(
    .FRAME_DIV (FRAME_DIV),
    .DLY_W     (DLY_W),
    .IDX_W     (knob_pkg::KNOB_IDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_tick (frame_tick),
    .a_sy       (a_sy),
    .b_sy       (b_sy),
    .edge_seen  (edge_seen),
    .delay_req  (delay_req),
    .prog_idx   (prog_idx)
);

// File: tb/sim_knob_delay_ctrl.sv
module sim_knob_delay_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_tick = 1'b0;
    logic       enc_a = 1'b1;
    logic       enc_b = 1'b0;
    logic [3:0] prog_sel = 4'd0;
    logic [7:0] delay_req;
    logic [5:0] prog_idx;

    int n_vec = 0;
    int n_bad = 0;
    int since_slot = 0;
    bit done = 0;

    // reference model state
    logic [5:0] hist[$];
    int  m_dly  = 0;
    int  m_idx  = 2;
    bit  m_flag = 0;
    int  m_cnt  = 0;

    always #5 clk = ~clk;

    knob_delay_ctrl u0 (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .enc_a      (enc_a),
        .enc_b      (enc_b),
        .prog_sel   (prog_sel),
        .delay_req  (delay_req),
        .prog_idx   (prog_idx)
    );

    // Behavioural reference: every input is seen two edges late (R9),
    // strobes are counted to 64 (R2), then the knob rules apply.
    always @(posedge clk) begin
        logic [5:0] used;
        if (rst) begin
            hist.delete();
            hist.push_back(6'd0);
            hist.push_back(6'd0);
            m_dly = 0; m_idx = 2; m_flag = 0; m_cnt = 0;
        end else begin
            used = hist.pop_front();
            hist.push_back({enc_a, enc_b, prog_sel});
            if (frame_tick) begin
                if (m_cnt == 63) begin
                    m_cnt = 0;
                    if (used[5]) m_flag = 0;
                    else if (!m_flag) begin
                        m_flag = 1;
                        if (used[4]) m_dly = (m_dly + 255) % 256;
                        else         m_dly = (m_dly + 1) % 256;
                    end
                    m_idx = 2 * int'(used[3:0]) + 2;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            n_vec++;
            if (int'(delay_req) != m_dly || int'(prog_idx) != m_idx) begin
                n_bad++;
                $display("FAIL R2 R9 R10 model: delay=%0d idx=%0d expected delay=%0d idx=%0d",
                         delay_req, prog_idx, m_dly, m_idx);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick_once(input int gap);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        repeat (gap) @(negedge clk);
        since_slot = (since_slot + 1) % 64;
    endtask

    // run strobes up to and including the next slot
    task automatic to_slot(input int gap);
        while (since_slot != 63) tick_once(gap);
        tick_once(0);
    endtask

    task automatic knob(input logic a, input logic b);
        enc_a = a;
        enc_b = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 delay after reset", int'(delay_req), 0);
        chk("R1 index after reset", int'(prog_idx), 2);

        prog_sel = 4'd5;
        knob(1'b0, 1'b0);
        to_slot(1);
        chk("R5 clockwise step", int'(delay_req), 1);
        chk("R1 R4 first low slot steps", int'(delay_req), 1);
        chk("R8 index 2*5+2", int'(prog_idx), 12);

        to_slot(0);
        chk("R4 no second step while A low", int'(delay_req), 1);

        knob(1'b1, 1'b0);
        to_slot(1);
        chk("R3 A high keeps delay", int'(delay_req), 1);
        knob(1'b0, 1'b1);
        to_slot(0);
        chk("R6 counter-clockwise step", int'(delay_req), 0);

        knob(1'b1, 1'b1);
        to_slot(0);
        knob(1'b0, 1'b1);
        to_slot(2);
        chk("R7 underflow wraps to 255", int'(delay_req), 255);
        knob(1'b1, 1'b0);
        to_slot(0);
        knob(1'b0, 1'b0);
        to_slot(0);
        chk("R7 overflow wraps to 0", int'(delay_req), 0);

        // R2: activity between slots only
        knob(1'b1, 1'b0);
        to_slot(0);
        repeat (20) tick_once(0);
        knob(1'b0, 1'b1);
        prog_sel = 4'd15;
        repeat (10) tick_once(1);
        chk("R2 delay untouched between slots", int'(delay_req), 0);
        chk("R2 index untouched between slots", int'(prog_idx), 12);
        knob(1'b1, 1'b0);
        prog_sel = 4'd0;
        to_slot(0);
        chk("R2 toggling before slot ignored", int'(delay_req), 0);
        chk("R8 index for selector 0", int'(prog_idx), 2);

        // R9: a change one cycle ahead of the slot edge is missed
        while (since_slot != 63) tick_once(0);
        enc_a = 1'b0;
        @(negedge clk);
        tick_once(0);
        chk("R9 late change not seen", int'(delay_req), 0);
        // now set two cycles ahead: seen
        knob(1'b1, 1'b0);
        to_slot(0);
        while (since_slot != 63) tick_once(0);
        enc_a = 1'b0;
        prog_sel = 4'd9;
        repeat (2) @(negedge clk);
        tick_once(0);
        chk("R9 change two cycles ahead seen", int'(delay_req), 1);
        chk("R8 index 2*9+2", int'(prog_idx), 20);

        // free-running mixed stimulus, checked by the model every cycle
        for (int i = 0; i < 700; i++) begin
            enc_a = 1'($urandom_range(0, 1));
            enc_b = 1'($urandom_range(0, 1));
            prog_sel = 4'($urandom_range(0, 15));
            for (int j = 0; j < int'($urandom_range(4, 40)); j++) begin
                frame_tick = 1'($urandom_range(0, 1));
                @(negedge clk);
            end
            frame_tick = 1'b0;
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule